// File: doc/BRIEF.md
# Nested Trap Context Stack

This block saves and restores processor context across nested traps. When a trap strobe arrives, it pushes the current program counter, next program counter, trap number and a packed state word into the slot for the current trap level. The state word holds the condition codes, address-space identifier, processor state and window pointer. The block then computes the trap vector from the trap base and the trap number, forces the processor state into privileged trap mode and raises the trap level.

Two return strobes pop the innermost level. "Done" resumes at the instruction after the trapped one. "Retry" re-executes the trapped instruction. Both restore the condition codes, address-space identifier, processor state and window pointer from the saved state word.

The trap level lives inside the block. All results are registered and appear one cycle after the strobe, together with a one-cycle update pulse.

Top module: `trap_ctx_unit`

## Requirements
- R1: After reset every output is zero: PC, next-PC, condition codes, ASI, processor state, window pointer, trap level, trap base, trap type, update pulse and error flag.
- R2: A trap taken at a level L below MAX_TL-1 (default MAX_TL=5) has the following results:
  - The level becomes L+1.
  - The processor state output becomes 12'h015: bit 4 enables floating point, bit 2 grants privilege and bit 0 selects the alternate globals.
  - The condition-code, ASI and window-pointer outputs take the current inputs.
  - The trap-type output takes the trap number.
- R3: On a trap, the trap base output keeps bits [63:15] of the current trap base. Bits [14:0] become the trap number shifted left by 5, with bit 14 set when the level before the trap exceeds 1. The PC output equals this trap base and the next-PC output equals the trap base plus 4.
- R4: A trap taken at level MAX_TL-1 also sets bit 5 (the red-state bit), giving a processor state of 12'h035, and the level becomes MAX_TL. The level never exceeds MAX_TL.
- R5: A trap arriving at level MAX_TL has the following effects:
  - It sets the error output, which stays set until reset.
  - It produces no update pulse and changes no output.
  - It saves nothing, so a later return still sees the level MAX_TL-1 slot intact.
- R6: A "done" return at level L>0 has the following results:
  - The level becomes L-1.
  - PC becomes the saved next-PC and next-PC becomes the saved next-PC plus 4.
  - The other fields are restored from the state word of slot L-1. That word packs the condition codes in [39:32], the ASI in [31:24], the processor state in [19:8] and the window pointer in [7:0].
- R7: A "retry" return at level L>0 decrements the level, sets PC to the saved PC and next-PC to the saved next-PC, and restores the same fields as R6.
- R8: When several strobes coincide, a trap wins over both returns, and "done" wins over "retry".
- R9: A return strobe at level 0 with no trap is ignored: no update pulse, and all outputs hold.
- R10: Every accepted trap or return raises the update pulse for exactly one cycle, with the new outputs in the cycle after the strobe. The level then differs by exactly one from its previous value, and outputs hold in cycles without an update.
- R11: After a return, the trap-type output shows the trap number saved for the new innermost level, or 0 when the level returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Trap strobe |
| trap_num_i | input | TT_W | Trap number |
| done_i | input | 1 | Return strobe, resume after the trapped instruction |
| retry_i | input | 1 | Return strobe, re-execute the trapped instruction |
| pc_i | input | PC_W | Current PC |
| npc_i | input | PC_W | Current next-PC |
| ccr_i | input | 8 | Current condition codes |
| asi_i | input | 8 | Current address-space identifier |
| pst_i | input | 12 | Current processor state |
| cwp_i | input | 8 | Current window pointer |
| tbr_i | input | PC_W | Current trap base |
| pc_o | output | PC_W | New PC |
| npc_o | output | PC_W | New next-PC |
| ccr_o | output | 8 | New condition codes |
| asi_o | output | 8 | New address-space identifier |
| pst_o | output | 12 | New processor state |
| cwp_o | output | 8 | New window pointer |
| tl_o | output | TL_W | Trap level |
| tbr_o | output | PC_W | New trap base |
| tt_o | output | TT_W | Trap type of the innermost level |
| upd_o | output | 1 | One-cycle pulse marking new outputs |
| err_o | output | 1 | Sticky error: trap at the maximum level |

## Verification
Every result of a trap or return is due one clock edge after the edge that samples the strobe. The error flag is due at that same edge. The bench drives strobes on the falling edge and samples on the next falling edge, so each sample lands half a cycle after the register update.

A driver queues the expected output set for each accepted strobe. A monitor pops one item every time the update pulse is seen and compares the whole set.

Ignored strobes (a return at level 0, a trap at the maximum level) push nothing. For these, the bench checks at the next falling edge that the pulse stayed low and the outputs held. A final check confirms that no expected item is left in the queue.

// File: rtl/trap_ctx_pkg.sv
package trap_ctx_pkg;
  localparam int CCR_W  = 8;
  localparam int ASI_W  = 8;
  localparam int PST_W  = 12;
  localparam int CWP_W  = 8;
  localparam int WORD_W = 40;
  // state word field positions
  localparam int CCR_LSB = 32;
  localparam int ASI_LSB = 24;
  localparam int PST_LSB = 8;
  localparam int CWP_LSB = 0;
  // processor state bits
  localparam int PST_AG   = 0;
  localparam int PST_PRIV = 2;
  localparam int PST_PEF  = 4;
  localparam int PST_RED  = 5;
  // trap base rewrite
  localparam int TBR_LOW_W  = 15;
  localparam int TBR_TT_LSB = 5;
  localparam int TBR_NEST   = 14;

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [CCR_W-1:0] ccr, input logic [ASI_W-1:0] asi,
    input logic [PST_W-1:0] pst, input logic [CWP_W-1:0] cwp);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CCR_LSB +: CCR_W] = ccr;
    w[ASI_LSB +: ASI_W] = asi;
    w[PST_LSB +: PST_W] = pst;
    w[CWP_LSB +: CWP_W] = cwp;
    return w;
  endfunction
endpackage

// File: rtl/trap_ctx_stack.sv
module trap_ctx_stack #(
  parameter int DEPTH = 5,
  parameter int ENT_W = 177,
  parameter int A_W   = 168,
  parameter int B_W   = 9,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [A_W-1:0]   rdata_a_o,
  output logic [B_W-1:0]   rdata_b_o
);
  logic [ENT_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (we_i && waddr_i == IDX_W'(g))      mem_q[g] <= wdata_i;
    end
  end

  // port A: low A_W bits, port B: top B_W bits
  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr_a_i == IDX_W'(i)) rdata_a_o = mem_q[i][A_W-1:0];
      if (raddr_b_i == IDX_W'(i)) rdata_b_o = mem_q[i][ENT_W-1 -: B_W];
    end
  end
endmodule

// File: rtl/trap_ctx_entry.sv
module trap_ctx_entry
  import trap_ctx_pkg::*;
#(
  parameter int MAX_TL = 5,
  parameter int PC_W   = 64,
  parameter int TT_W   = 9,
  localparam int TL_W  = $clog2(MAX_TL + 1)
) (
  input  logic [TL_W-1:0]           tl_i,
  input  logic [TT_W-1:0]           tt_i,
  input  logic [PC_W-1:TBR_LOW_W]   tbr_hi_i,
  output logic [PST_W-1:0]          pst_o,
  output logic [PC_W-1:0]           tbr_o,
  output logic [PC_W-1:0]           pc_o,
  output logic [PC_W-1:0]           npc_o
);
  logic [TBR_LOW_W-1:0] low;

  always_comb begin
    low = TBR_LOW_W'(tt_i) << TBR_TT_LSB;
    if (tl_i > TL_W'(1)) low[TBR_NEST] = 1'b1;
    tbr_o = {tbr_hi_i, low};
    pc_o  = tbr_o;
    npc_o = tbr_o + PC_W'(4);
  end

  always_comb begin
    pst_o = '0;
    pst_o[PST_PEF]  = 1'b1;
    pst_o[PST_PRIV] = 1'b1;
    pst_o[PST_AG]   = 1'b1;
    if (tl_i == TL_W'(MAX_TL - 1)) pst_o[PST_RED] = 1'b1;
  end
endmodule

// File: rtl/trap_ctx_return.sv
module trap_ctx_return
  import trap_ctx_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic              sel_done_i,
  input  logic [PC_W-1:0]   spc_i,
  input  logic [PC_W-1:0]   snpc_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   npc_o,
  output logic [CCR_W-1:0]  ccr_o,
  output logic [ASI_W-1:0]  asi_o,
  output logic [PST_W-1:0]  pst_o,
  output logic [CWP_W-1:0]  cwp_o
);
  always_comb begin
    if (sel_done_i) begin
      pc_o  = snpc_i;
      npc_o = snpc_i + PC_W'(4);
    end else begin
      pc_o  = spc_i;
      npc_o = snpc_i;
    end
    ccr_o = word_i[CCR_LSB +: CCR_W];
    asi_o = word_i[ASI_LSB +: ASI_W];
    pst_o = word_i[PST_LSB +: PST_W];
    cwp_o = word_i[CWP_LSB +: CWP_W];
  end
endmodule

// File: rtl/trap_ctx_unit.sv
module trap_ctx_unit
  import trap_ctx_pkg::*;
#(
  parameter int MAX_TL = 5,
  parameter int PC_W   = 64,
  parameter int TT_W   = 9,
  localparam int TL_W  = $clog2(MAX_TL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_i,
  input  logic [TT_W-1:0]  trap_num_i,
  input  logic             done_i,
  input  logic             retry_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  npc_i,
  input  logic [7:0]       ccr_i,
  input  logic [7:0]       asi_i,
  input  logic [11:0]      pst_i,
  input  logic [7:0]       cwp_i,
  input  logic [PC_W-1:0]  tbr_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  npc_o,
  output logic [7:0]       ccr_o,
  output logic [7:0]       asi_o,
  output logic [11:0]      pst_o,
  output logic [7:0]       cwp_o,
  output logic [TL_W-1:0]  tl_o,
  output logic [PC_W-1:0]  tbr_o,
  output logic [TT_W-1:0]  tt_o,
  output logic             upd_o,
  output logic             err_o
);
  localparam int IDX_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;
  localparam int A_W   = WORD_W + 2 * PC_W;
  localparam int ENT_W = A_W + TT_W;
  localparam int NPC_LSB = WORD_W;
  localparam int PC_LSB  = WORD_W + PC_W;

  logic [TL_W-1:0] tl_q;
  logic [PC_W-1:0] pc_q, npc_q, tbr_q;
  logic [7:0]      ccr_q, asi_q, cwp_q;
  logic [11:0]     pst_q;
  logic [TT_W-1:0] tt_q;
  logic            upd_q, err_q;

  // event decode; trap first, then done, then retry
  logic at_max, at_zero, trap_go, trap_bad, ret_go;
  assign at_max   = (tl_q == TL_W'(MAX_TL));
  assign at_zero  = (tl_q == '0);
  assign trap_go  = trap_i && !at_max;
  assign trap_bad = trap_i && at_max;
  assign ret_go   = !trap_i && (done_i || retry_i) && !at_zero;

  // stack
  logic [ENT_W-1:0] wdata;
  logic [IDX_W-1:0] widx, ridx_a, ridx_b;
  logic [A_W-1:0]   rd_a;
  logic [TT_W-1:0]  rd_b_tt;

  assign wdata  = {trap_num_i, pc_i, npc_i, pack_word(ccr_i, asi_i, pst_i, cwp_i)};
  assign widx   = IDX_W'(tl_q);
  assign ridx_a = IDX_W'(tl_q - TL_W'(1));
  assign ridx_b = IDX_W'(tl_q - TL_W'(2));

  trap_ctx_stack #(
    .DEPTH (MAX_TL),
    .ENT_W (ENT_W),
    .A_W   (A_W),
    .B_W   (TT_W)
  ) i_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (trap_go),
    .waddr_i   (widx),
    .wdata_i   (wdata),
    .raddr_a_i (ridx_a),
    .raddr_b_i (ridx_b),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b_tt)
  );

  // trap entry path
  logic [PST_W-1:0] e_pst;
  logic [PC_W-1:0]  e_tbr, e_pc, e_npc;

  trap_ctx_entry #(
    .MAX_TL (MAX_TL),
    .PC_W   (PC_W),
    .TT_W   (TT_W)
  ) i_entry (
    .tl_i     (tl_q),
    .tt_i     (trap_num_i),
    .tbr_hi_i (tbr_i[PC_W-1:TBR_LOW_W]),
    .pst_o    (e_pst),
    .tbr_o    (e_tbr),
    .pc_o     (e_pc),
    .npc_o    (e_npc)
  );

  // return path
  logic [PC_W-1:0]  r_pc, r_npc;
  logic [CCR_W-1:0] r_ccr;
  logic [ASI_W-1:0] r_asi;
  logic [PST_W-1:0] r_pst;
  logic [CWP_W-1:0] r_cwp;

  trap_ctx_return #(
    .PC_W (PC_W)
  ) i_return (
    .sel_done_i (done_i),
    .spc_i      (rd_a[PC_LSB +: PC_W]),
    .snpc_i     (rd_a[NPC_LSB +: PC_W]),
    .word_i     (rd_a[WORD_W-1:0]),
    .pc_o       (r_pc),
    .npc_o      (r_npc),
    .ccr_o      (r_ccr),
    .asi_o      (r_asi),
    .pst_o      (r_pst),
    .cwp_o      (r_cwp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tl_q  <= '0;
      pc_q  <= '0;
      npc_q <= '0;
      tbr_q <= '0;
      ccr_q <= '0;
      asi_q <= '0;
      cwp_q <= '0;
      pst_q <= '0;
      tt_q  <= '0;
      upd_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      upd_q <= trap_go || ret_go;
      if (trap_bad) err_q <= 1'b1;
      if (trap_go) begin
        tl_q  <= tl_q + TL_W'(1);
        pc_q  <= e_pc;
        npc_q <= e_npc;
        tbr_q <= e_tbr;
        pst_q <= e_pst;
        ccr_q <= ccr_i;
        asi_q <= asi_i;
        cwp_q <= cwp_i;
        tt_q  <= trap_num_i;
      end else if (ret_go) begin
        tl_q  <= tl_q - TL_W'(1);
        pc_q  <= r_pc;
        npc_q <= r_npc;
        pst_q <= r_pst;
        ccr_q <= r_ccr;
        asi_q <= r_asi;
        cwp_q <= r_cwp;
        tt_q  <= (tl_q >= TL_W'(2)) ? rd_b_tt : '0;
      end
    end
  end

  assign pc_o  = pc_q;
  assign npc_o = npc_q;
  assign ccr_o = ccr_q;
  assign asi_o = asi_q;
  assign pst_o = pst_q;
  assign cwp_o = cwp_q;
  assign tl_o  = tl_q;
  assign tbr_o = tbr_q;
  assign tt_o  = tt_q;
  assign upd_o = upd_q;
  assign err_o = err_q;
endmodule

// File: rtl/trap_ctx_chk.sv
module trap_ctx_chk
  import trap_ctx_pkg::*;
#(
  parameter int MAX_TL = 5,
  parameter int PC_W   = 64,
  localparam int TL_W  = $clog2(MAX_TL + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_i,
  input logic            done_i,
  input logic            retry_i,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] npc_o,
  input logic [11:0]     pst_o,
  input logic [TL_W-1:0] tl_o,
  input logic [PC_W-1:0] tbr_o,
  input logic            upd_o,
  input logic            err_o
);
  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_full_trap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i && tl_o == TL_W'(MAX_TL) |=> !upd_o && err_o);

  assert_tl_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tl_o <= TL_W'(MAX_TL));

  assert_red_at_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o && tl_o == TL_W'(MAX_TL) |-> pst_o[PST_RED]);

  assert_tl_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (tl_o == $past(tl_o) + TL_W'(1)) || (tl_o == $past(tl_o) - TL_W'(1)));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(pc_o) && $stable(npc_o) && $stable(tl_o) && $stable(pst_o));

  assert_vector_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o && (tl_o > $past(tl_o)) |-> pc_o == tbr_o && npc_o == tbr_o + PC_W'(4));

  assert_zero_return_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i || retry_i) && !trap_i && tl_o == '0 |=> !upd_o);
endmodule

bind trap_ctx_unit trap_ctx_chk #(
  .MAX_TL (MAX_TL),
  .PC_W   (PC_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trap_i  (trap_i),
  .done_i  (done_i),
  .retry_i (retry_i),
  .pc_o    (pc_o),
  .npc_o   (npc_o),
  .pst_o   (pst_o),
  .tl_o    (tl_o),
  .tbr_o   (tbr_o),
  .upd_o   (upd_o),
  .err_o   (err_o)
);

// File: tb/test_trap_ctx_unit.sv
`timescale 1ns/1ps
module test_trap_ctx_unit;
  localparam int MAX = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trap_i = 1'b0, done_i = 1'b0, retry_i = 1'b0;
  logic [8:0]  trap_num_i = '0;
  logic [63:0] pc_i = '0, npc_i = '0, tbr_i = '0;
  logic [7:0]  ccr_i = '0, asi_i = '0, cwp_i = '0;
  logic [11:0] pst_i = '0;
  logic [63:0] pc_o, npc_o, tbr_o;
  logic [7:0]  ccr_o, asi_o, cwp_o;
  logic [11:0] pst_o;
  logic [2:0]  tl_o;
  logic [8:0]  tt_o;
  logic        upd_o, err_o;

  trap_ctx_unit i_trap_ctx_unit (
    .clk_i, .rst_ni, .trap_i, .trap_num_i, .done_i, .retry_i,
    .pc_i, .npc_i, .ccr_i, .asi_i, .pst_i, .cwp_i, .tbr_i,
    .pc_o, .npc_o, .ccr_o, .asi_o, .pst_o, .cwp_o, .tl_o, .tbr_o,
    .tt_o, .upd_o, .err_o
  );

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic [63:0] pc, npc, tbr;
    logic [7:0]  ccr, asi, cwp;
    logic [11:0] pst;
    logic [2:0]  tl;
    logic [8:0]  tt;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int checks = 0, failures = 0;
  int k = 0;
  bit finished = 0;

  logic [63:0] s_pc[MAX], s_npc[MAX];
  logic [7:0]  s_ccr[MAX], s_asi[MAX], s_cwp[MAX];
  logic [11:0] s_pst[MAX];
  logic [8:0]  s_tt[MAX];
  int m_tl = 0;

  function automatic string fmt(exp_t e);
    return $sformatf("pc=%h npc=%h tbr=%h ccr=%h asi=%h cwp=%h pst=%h tl=%0d tt=%h",
      e.pc, e.npc, e.tbr, e.ccr, e.asi, e.cwp, e.pst, e.tl, e.tt);
  endfunction

  function automatic exp_t actual();
    exp_t a;
    a.pc = pc_o; a.npc = npc_o; a.tbr = tbr_o; a.ccr = ccr_o; a.asi = asi_o;
    a.cwp = cwp_o; a.pst = pst_o; a.tl = tl_o; a.tt = tt_o; a.tag = "";
    return a;
  endfunction

  function automatic bit same(exp_t a, exp_t e);
    return a.pc == e.pc && a.npc == e.npc && a.tbr == e.tbr && a.ccr == e.ccr &&
           a.asi == e.asi && a.cwp == e.cwp && a.pst == e.pst && a.tl == e.tl &&
           a.tt == e.tt;
  endfunction

  task automatic check(bit ok, string tag, string act, string expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual: %s expected: %s", tag, act, expv);
    end
  endtask

  // monitor: pops one expected item per update pulse
  always @(negedge clk_i) begin
    if (rst_ni && upd_o && !finished) begin
      if (q.size() == 0) begin
        check(0, "R10 unexpected update", fmt(actual()), "no update");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(same(actual(), e), e.tag, fmt(actual()), fmt(e));
      end
    end
  end

  // driver: one strobe cycle, expected result queued from the requirements
  task automatic step(bit t, bit d, bit r, logic [8:0] tt, string tag);
    exp_t e;
    bit   ignored;
    k++;
    @(negedge clk_i);
    pc_i  = 64'h0000_2000_0000_0000 + 64'(k) * 64'h140;
    npc_i = pc_i + 64'd4;
    ccr_i = 8'(k * 7 + 3);
    asi_i = 8'(k * 13 + 128);
    pst_i = 12'(k * 37 + 5);
    cwp_i = 8'(k % 8);
    tbr_i = 64'hABCD_0000_0001_7FFF + (64'(k) << 20);
    trap_num_i = tt;
    trap_i = t; done_i = d; retry_i = r;
    e = cur;
    e.tag = tag;
    ignored = 0;
    if (t) begin
      if (m_tl == MAX) begin
        ignored = 1;
      end else begin
        s_pc[m_tl] = pc_i; s_npc[m_tl] = npc_i; s_ccr[m_tl] = ccr_i;
        s_asi[m_tl] = asi_i; s_pst[m_tl] = pst_i; s_cwp[m_tl] = cwp_i;
        s_tt[m_tl] = tt;
        e.tbr = {tbr_i[63:15], (15'(tt) << 5) | ((m_tl > 1) ? 15'h4000 : 15'h0)};
        e.pc  = e.tbr;
        e.npc = e.tbr + 64'd4;
        e.pst = (m_tl == MAX - 1) ? 12'h035 : 12'h015;
        e.ccr = ccr_i; e.asi = asi_i; e.cwp = cwp_i; e.tt = tt;
        m_tl++;
        e.tl = 3'(m_tl);
      end
    end else if ((d || r) && m_tl > 0) begin
      m_tl--;
      if (d) begin
        e.pc = s_npc[m_tl]; e.npc = s_npc[m_tl] + 64'd4;
      end else begin
        e.pc = s_pc[m_tl];  e.npc = s_npc[m_tl];
      end
      e.ccr = s_ccr[m_tl]; e.asi = s_asi[m_tl]; e.pst = s_pst[m_tl];
      e.cwp = s_cwp[m_tl];
      e.tt  = (m_tl > 0) ? s_tt[m_tl-1] : 9'h0;
      e.tl  = 3'(m_tl);
    end else begin
      ignored = 1;
    end
    if (!ignored) begin
      q.push_back(e);
      cur = e;
    end
    @(negedge clk_i);
    trap_i = 0; done_i = 0; retry_i = 0;
    if (ignored) begin
      check(!upd_o && same(actual(), cur), {tag, " ignored strobe"},
            $sformatf("upd=%0d %s", upd_o, fmt(actual())),
            $sformatf("upd=0 %s", fmt(cur)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog R10 actual: timeout expected: completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cur = '{pc: 0, npc: 0, tbr: 0, ccr: 0, asi: 0, cwp: 0, pst: 0, tl: 0, tt: 0, tag: ""};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(same(actual(), cur) && !upd_o && !err_o, "R1 reset",
          $sformatf("upd=%0d err=%0d %s", upd_o, err_o, fmt(actual())), fmt(cur));

    step(0, 1, 0, 9'h0,  "R9 done at level 0");
    step(0, 0, 1, 9'h0,  "R9 retry at level 0");
    step(1, 0, 0, 9'h041, "R2 R3 trap from level 0");
    step(1, 0, 0, 9'h1FF, "R3 trap from level 1, no nest bit");
    step(1, 1, 1, 9'h022, "R8 trap beats returns, R3 nest bit at level 2");
    step(0, 0, 1, 9'h0,  "R7 retry from level 3, R11");
    step(0, 1, 1, 9'h0,  "R8 done beats retry, R6");
    step(0, 1, 0, 9'h0,  "R6 done to level 0, R11 tt zero");
    check(err_o == 1'b0, "R5 no error yet", $sformatf("%0d", err_o), "0");
    for (int i = 0; i < MAX; i++)
      step(1, 0, 0, 9'(9'h010 + i), (i == MAX - 1) ? "R4 trap at MAX-1 sets red" : "R2 fill levels");
    step(1, 0, 0, 9'h0AA, "R5 trap at MAX ignored");
    check(err_o == 1'b1, "R5 error flag set", $sformatf("%0d", err_o), "1");
    step(0, 0, 1, 9'h0,  "R5 R7 top slot intact after overflow");
    step(1, 0, 0, 9'h033, "R4 red again at MAX-1");
    for (int i = 0; i < MAX; i++)
      step(0, (i % 2) == 0, (i % 2) == 1, 9'h0, "R6 R7 R11 unwind");
    step(0, 1, 0, 9'h0,  "R9 done after unwind");
    check(err_o == 1'b1, "R5 error stays set", $sformatf("%0d", err_o), "1");
    repeat (3) @(negedge clk_i);
    check(q.size() == 0, "R10 all expected updates seen",
          $sformatf("%0d left", q.size()), "0 left");
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule